// File: doc/BRIEF.md
# Three-wire serial EEPROM device model

This block is the device end of a three-wire serial non-volatile memory, written as synthesizable logic that runs on a fast system clock. The host drives chip select, a slow shift clock and a serial data line. The block returns serial data on one output pin, with an enable for tri-state. Both shift-clock and chip-select edges are sampled on the system clock. The 1024-bit array is held in flip-flops. An organisation input views it either as 16-bit words or as bytes.

Every instruction is a start bit, a two-bit opcode, an address and, for writes, a data field. The block supports single-word read, write and erase, plus erase-all and write-all. It also has a protection state, which must be switched on before any programming command is accepted. Programming takes a fixed number of system-clock cycles, counted by a timer. While that timer runs, the data pin can be polled for busy or ready status.

Top module: `eep_slave`

## Requirements
- R1: After reset, programming is disabled, dout_oe is low and every bit of the array reads 1.
- R2: DI is sampled on SK rising edges while CS is high. Zeros before the first 1 are ignored. That first 1 is the start bit, and the next two bits are the opcode: 10 read, 01 write, 11 erase word, 00 special command.
- R3: With org high, the address is 6 bits and the data is 16 bits. With org low, the address is 7 bits and the data is 8 bits. Byte address b selects word b>>1: bits 15:8 when b[0]=0 and bits 7:0 when b[0]=1. All fields are sent MSB first.
- R4: On a read, the SK rise that samples the last address bit drives a dummy 0 on dout. Each later rise drives the next data bit, MSB first. A read works whether or not programming is enabled.
- R5: For opcode 00, the top two address bits choose the command: 11 enable programming, 00 disable programming, 10 erase all, 01 write all (data field follows). The remaining address bits are don't-care but must still be clocked in.
- R6: Write, erase, erase-all and write-all leave the array unchanged and start no busy period while programming is disabled. Programming stays enabled from an enable command until a disable command or reset.
- R7: Erase sets every bit of the addressed word (or byte) to 1. Erase-all sets the whole array to 1. Write-all stores the pattern in every word, or in every byte when org is low. A write needs no prior erase.
- R8: A busy period of PROG_CYCLES system clocks starts right after the last data bit (write, write-all) or the last address bit (erase, erase-all). Any instruction started while busy is ignored up to the next CS low.
- R9: If CS is raised while busy, dout_oe goes high and dout shows 0 until the period ends, then 1. If CS is raised only after the period has ended, no status is driven.
- R10: dout_oe is low whenever CS is low, and also whenever no read and no status is in progress.
- R11: If CS falls before the last bit of a frame, the frame is dropped and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| org | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data or ready/busy status |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The assertions assume that SK, CS and DI change far more slowly than the system clock: each SK phase lasts several system clocks, and DI is stable around each SK rise. They also assume that org is changed only while CS is low. The bench changes every input on the falling system-clock edge, holds each SK level for four system clocks, and changes org only between frames. Under these conditions each shift-clock rise is seen exactly once.

// File: rtl/eep_pkg.sv
// Shared types and codes of the serial EEPROM device model.
// Assumes nothing beyond the codes being fixed by the serial protocol.
package eep_pkg;

    // Array operation requested by the frame decoder.
    typedef enum logic [2:0] {
        MOP_NONE,
        MOP_WORD_WR,
        MOP_WORD_ERASE,
        MOP_ALL_WR,
        MOP_ALL_ERASE
    } mem_op_e;

    // Frame decoder state.
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADDR,
        FS_DATA,
        FS_READ,
        FS_HOLD
    } frame_st_e;

    // Opcode field following the start bit.
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_ERASE   = 2'b11;
    localparam logic [1:0] OPC_SPECIAL = 2'b00;

    // Sub-command carried in the top two address bits of a special frame.
    localparam logic [1:0] SUB_ENABLE  = 2'b11;
    localparam logic [1:0] SUB_DISABLE = 2'b00;
    localparam logic [1:0] SUB_ERAL    = 2'b10;
    localparam logic [1:0] SUB_WRAL    = 2'b01;

endpackage

// File: rtl/eep_mem.sv
// Register-file array of the EEPROM model.
// Holds NWORDS words of WORD_W bits. In byte view (wide=0) an address
// selects word addr>>1, upper half when addr[0]=0. Applies one operation
// per cycle; read port is combinational and returns the byte left-aligned.
// Assumes op is a single-cycle pulse.
module eep_mem
    import eep_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NWORDS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wide,
    input  mem_op_e              op,
    input  logic [AW8-1:0]       addr,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [AW8-1:0]       rd_addr,
    output logic [WORD_W-1:0]    rdata
);
    localparam int AW16   = $clog2(NWORDS);
    localparam int AW8    = AW16 + 1;
    localparam int BYTE_W = WORD_W / 2;

    logic [NWORDS-1:0][WORD_W-1:0] words;

    // Replace one byte lane of a word; lo selects the lower lane.
    function automatic logic [WORD_W-1:0] lane_put(
        input logic [WORD_W-1:0] w,
        input logic              lo,
        input logic [BYTE_W-1:0] b
    );
        return lo ? {w[WORD_W-1:BYTE_W], b} : {b, w[BYTE_W-1:0]};
    endfunction

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic [WORD_W-1:0] nxt;
        logic              hit;
        logic              we;

        // Work out whether and how this word changes this cycle.
        always_comb begin
            hit = wide ? (addr[AW16-1:0] == AW16'(i)) : (addr[AW8-1:1] == AW16'(i));
            we  = 1'b0;
            nxt = word_q;
            case (op)
                MOP_WORD_WR: if (hit) begin
                    we  = 1'b1;
                    nxt = wide ? wdata : lane_put(word_q, addr[0], wdata[BYTE_W-1:0]);
                end
                MOP_WORD_ERASE: if (hit) begin
                    we  = 1'b1;
                    nxt = wide ? '1 : lane_put(word_q, addr[0], '1);
                end
                MOP_ALL_WR: begin
                    we  = 1'b1;
                    nxt = wide ? wdata : {2{wdata[BYTE_W-1:0]}};
                end
                MOP_ALL_ERASE: begin
                    we  = 1'b1;
                    nxt = '1;
                end
                default: ;
            endcase
        end

        // Word storage, erased state at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)  word_q <= '1;
            else if (we) word_q <= nxt;
        end

        assign words[i] = word_q;
    end

    logic [AW16-1:0]   rd_idx;
    logic [WORD_W-1:0] rd_word;

    // Read mux, byte view returns the selected lane in the upper bits.
    always_comb begin
        rd_idx  = wide ? rd_addr[AW16-1:0] : rd_addr[AW8-1:1];
        rd_word = words[rd_idx];
        if (wide)            rdata = rd_word;
        else if (rd_addr[0]) rdata = {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
        else                 rdata = {rd_word[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
    end

endmodule

// File: rtl/eep_frame.sv
// Serial frame decoder of the EEPROM model.
// Detects SK rising edges on the system clock, waits for a start bit,
// collects opcode, address and data, and issues single-cycle command
// pulses. Drives the read bit stream (dummy 0 then data MSB first).
// Assumes SK phases last at least two system clocks and CS low resets it.
module eep_frame
    import eep_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int AW8    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              wide,
    input  logic              busy,
    input  logic [WORD_W-1:0] rdata,
    output logic [AW8-1:0]    rd_addr,
    output mem_op_e           cmd_op,
    output logic [AW8-1:0]    cmd_addr,
    output logic [WORD_W-1:0] cmd_data,
    output logic              en_set,
    output logic              en_clr,
    output logic              start_seen,
    output logic              rd_active,
    output logic              rd_bit
);
    localparam int AW16   = AW8 - 1;
    localparam int BYTE_W = WORD_W / 2;
    localparam int CMAX   = (WORD_W > AW8) ? WORD_W : AW8;
    localparam int CW     = $clog2(CMAX);

    frame_st_e         state;
    logic              sk_q;
    logic              rise;
    logic [1:0]        opc_q;
    logic [CW-1:0]     cnt;
    logic [AW8-1:0]    addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] out_q;
    logic [AW8-1:0]    addr_next;
    logic [WORD_W-1:0] data_next;
    logic [1:0]        sub;
    logic [CW-1:0]     addr_last;
    logic [CW-1:0]     data_last;

    // Field shift values and field lengths for the current organisation.
    always_comb begin
        rise      = sk & ~sk_q;
        addr_next = {addr_q[AW8-2:0], di};
        data_next = {data_q[WORD_W-2:0], di};
        sub       = wide ? addr_next[AW16-1:AW16-2] : addr_next[AW8-1:AW8-2];
        addr_last = wide ? CW'(AW16 - 1) : CW'(AW8 - 1);
        data_last = wide ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
    end

    assign rd_addr   = addr_next;
    assign rd_active = (state == FS_READ);

    // Shift-clock edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    // Frame state machine with command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FS_IDLE;
            opc_q      <= '0;
            cnt        <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            out_q      <= '0;
            rd_bit     <= 1'b0;
            cmd_op     <= MOP_NONE;
            cmd_addr   <= '0;
            cmd_data   <= '0;
            en_set     <= 1'b0;
            en_clr     <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            cmd_op     <= MOP_NONE;
            en_set     <= 1'b0;
            en_clr     <= 1'b0;
            start_seen <= 1'b0;
            if (!cs) begin
                state <= FS_IDLE;
                cnt   <= '0;
            end else if (rise) begin
                case (state)
                    FS_IDLE: if (di) begin
                        cnt <= '0;
                        if (busy) begin
                            state <= FS_HOLD;
                        end else begin
                            state      <= FS_OPC;
                            start_seen <= 1'b1;
                        end
                    end
                    FS_OPC: begin
                        opc_q <= {opc_q[0], di};
                        if (cnt == CW'(1)) begin
                            state <= FS_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_ADDR: begin
                        addr_q <= addr_next;
                        if (cnt == addr_last) begin
                            cnt <= '0;
                            case (opc_q)
                                OPC_READ: begin
                                    out_q  <= rdata;
                                    rd_bit <= 1'b0;
                                    state  <= FS_READ;
                                end
                                OPC_WRITE: state <= FS_DATA;
                                OPC_ERASE: begin
                                    cmd_op   <= MOP_WORD_ERASE;
                                    cmd_addr <= addr_next;
                                    state    <= FS_HOLD;
                                end
                                default: begin
                                    state <= FS_HOLD;
                                    case (sub)
                                        SUB_ENABLE:  en_set <= 1'b1;
                                        SUB_DISABLE: en_clr <= 1'b1;
                                        SUB_ERAL:    cmd_op <= MOP_ALL_ERASE;
                                        default:     state  <= FS_DATA;
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        data_q <= data_next;
                        if (cnt == data_last) begin
                            cmd_op   <= (opc_q == OPC_WRITE) ? MOP_WORD_WR : MOP_ALL_WR;
                            cmd_addr <= addr_q;
                            cmd_data <= data_next;
                            state    <= FS_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_READ: begin
                        rd_bit <= out_q[WORD_W-1];
                        out_q  <= {out_q[WORD_W-2:0], 1'b0};
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/eep_ptimer.sv
// Programming-cycle timer and ready/busy status tracker.
// Counts PROG_CYCLES system clocks from a start pulse. Status becomes
// visible when CS rises during the busy period and stays until CS falls
// or a new start bit is accepted.
// Assumes start is a single-cycle pulse.
module eep_ptimer #(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cs,
    input  logic start_seen,
    output logic busy,
    output logic stat_vis
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] cnt;
    logic          cs_q;

    assign busy = (cnt != '0);

    // Down-counter for the self-timed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (start)  cnt <= TW'(PROG_CYCLES);
        else if (busy)   cnt <= cnt - 1'b1;
    end

    // Status visibility, armed by a CS rise while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= 1'b0;
            stat_vis <= 1'b0;
        end else begin
            cs_q <= cs;
            if (!cs)                   stat_vis <= 1'b0;
            else if (cs && !cs_q && busy) stat_vis <= 1'b1;
            else if (start_seen)       stat_vis <= 1'b0;
        end
    end

endmodule

// File: rtl/eep_slave.sv
// Top of the three-wire serial EEPROM device model.
// Ties the frame decoder, array, programming timer and protection state
// together, and muxes read data and ready/busy status onto dout.
// Assumes org is changed only while cs is low.
module eep_slave
    import eep_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int MEM_BITS    = 1024,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic dout,
    output logic dout_oe
);
    localparam int NWORDS = MEM_BITS / WORD_W;
    localparam int AW8    = $clog2(NWORDS) + 1;

    mem_op_e           cmd_op;
    mem_op_e           mem_op;
    logic [AW8-1:0]    cmd_addr;
    logic [AW8-1:0]    rd_addr;
    logic [WORD_W-1:0] cmd_data;
    logic [WORD_W-1:0] rdata;
    logic              en_set;
    logic              en_clr;
    logic              start_seen;
    logic              rd_active;
    logic              rd_bit;
    logic              busy;
    logic              stat_vis;
    logic              prog_en;
    logic              go;

    eep_frame #(.WORD_W(WORD_W), .AW8(AW8)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .wide(org),
        .busy(busy), .rdata(rdata), .rd_addr(rd_addr), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .en_set(en_set),
        .en_clr(en_clr), .start_seen(start_seen), .rd_active(rd_active),
        .rd_bit(rd_bit)
    );

    // Protection state: disabled at reset, toggled by special commands.
    always_ff @(posedge clk) begin
        if (!rst_n)      prog_en <= 1'b0;
        else if (en_set) prog_en <= 1'b1;
        else if (en_clr) prog_en <= 1'b0;
    end

    // Only pass programming commands while enabled.
    always_comb begin
        go     = (cmd_op != MOP_NONE) && prog_en;
        mem_op = go ? cmd_op : MOP_NONE;
    end

    eep_mem #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_mem (
        .clk(clk), .rst_n(rst_n), .wide(org), .op(mem_op), .addr(cmd_addr),
        .wdata(cmd_data), .rd_addr(rd_addr), .rdata(rdata)
    );

    eep_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(go), .cs(cs),
        .start_seen(start_seen), .busy(busy), .stat_vis(stat_vis)
    );

    // Output pin mux: read stream, else ready/busy status.
    always_comb begin
        dout_oe = cs & (rd_active | stat_vis);
        dout    = rd_active ? rd_bit : (stat_vis & ~busy);
    end

endmodule

// File: rtl/eep_slave_chk.sv
// Property checker for eep_slave, attached with bind.
// Assumes a synchronous active-low reset held at least one clock at start.
module eep_slave_chk
    import eep_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    cs,
    input logic    dout,
    input logic    dout_oe,
    input logic    prog_en,
    input logic    busy,
    input logic    en_clr,
    input mem_op_e cmd_op
);
    assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_oe);

    assert_prog_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_en));

    assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_en) |-> $past(en_clr));

    assert_no_cmd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cmd_op == MOP_NONE));

    assert_quiet_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !dout_oe);

    assert_busy_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && busy) |-> !dout);
endmodule

bind eep_slave eep_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_oe(dout_oe),
    .prog_en(prog_en), .busy(busy), .en_clr(en_clr), .cmd_op(cmd_op)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
    localparam int PROG = 40;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic dout, dout_oe;
    logic [15:0] model [64];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    eep_slave #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int aw(); return org ? 6 : 7; endfunction
    function automatic int dw(); return org ? 16 : 8; endfunction

    function automatic logic [15:0] mexp(input int a);
        if (org) return model[a];
        return a[0] ? {8'h0, model[a>>1][7:0]} : {8'h0, model[a>>1][15:8]};
    endfunction

    task automatic mput(input int a, input logic [15:0] d);
        if (org) model[a] = d;
        else if (a[0]) model[a>>1][7:0] = d[7:0];
        else model[a>>1][15:8] = d[7:0];
    endtask

    task automatic pulse(input logic b);
        @(negedge clk) di = b;
        repeat (HALF) @(negedge clk);
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        sk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic sel();
        @(negedge clk) cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input int a, input string tag);
        logic [15:0] v;
        v = '0;
        sel();
        send(3'b110, 3);
        send(a, aw());
        chk(dout_oe && !dout, "R4 dummy", {dout_oe, dout}, 2'b10);
        for (int i = 0; i < dw(); i++) begin
            pulse(1'b0);
            v = {v[14:0], dout};
        end
        desel();
        chk(v == mexp(a), tag, v, mexp(a));
    endtask

    task automatic prog_wait();
        repeat (PROG + 10) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d, input bit en);
        sel(); send(3'b101, 3); send(a, aw()); send(d, dw()); desel(); prog_wait();
        if (en) mput(a, d);
    endtask

    task automatic er(input int a, input bit en);
        sel(); send(3'b111, 3); send(a, aw()); desel(); prog_wait();
        if (en) mput(a, 16'hFFFF);
    endtask

    task automatic special(input logic [1:0] sub, input bit with_data, input logic [15:0] d);
        sel();
        send(3'b100, 3);
        send(org ? {sub, 4'b0} : {sub, 5'b0}, aw());
        if (with_data) send(d, dw());
        desel();
        prog_wait();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!dout_oe, "R1 oe low after reset", dout_oe, 0);
        sel();
        chk(!dout_oe, "R10 oe low idle with cs high", dout_oe, 0);
        desel();
        rd(5, "R1 erased after reset");

        // R6: write while disabled is ignored, read still works (R4)
        wr(5, 16'h1234, 1'b0);
        rd(5, "R6 write ignored when disabled");

        special(2'b11, 1'b0, 16'h0);           // R5 enable
        wr(5, 16'hA5C3, 1'b1);
        rd(5, "R7 write word");
        wr(5, 16'h1234, 1'b1);
        rd(5, "R7 overwrite without erase");

        // R2: leading zeros before start bit
        sel();
        send(3'b000, 3);
        send(3'b110, 3);
        send(5, 6);
        chk(dout_oe && !dout, "R2 leading zeros dummy", {dout_oe, dout}, 2'b10);
        begin
            logic [15:0] v = '0;
            for (int i = 0; i < 16; i++) begin pulse(1'b0); v = {v[14:0], dout}; end
            chk(v == model[5], "R2 read after leading zeros", v, model[5]);
        end
        desel();

        er(5, 1'b1);
        rd(5, "R7 erase word");

        // R9/R8: status polled while busy, then ready
        sel(); send(3'b101, 3); send(9, 6); send(16'h0F0F, 16); desel();
        mput(9, 16'h0F0F);
        sel();
        chk(dout_oe && !dout, "R9 busy status", {dout_oe, dout}, 2'b10);
        repeat (PROG - 20) @(negedge clk);
        chk(dout_oe && !dout, "R8 still busy", {dout_oe, dout}, 2'b10);
        repeat (20) @(negedge clk);
        chk(dout_oe && dout, "R9 ready status", {dout_oe, dout}, 2'b11);
        desel();
        chk(!dout_oe, "R10 oe low after cs low", dout_oe, 0);
        rd(9, "R8 write landed");

        // R9: cs raised after cycle ended shows no status
        sel(); send(3'b101, 3); send(10, 6); send(16'h3344, 16); desel();
        mput(10, 16'h3344);
        repeat (PROG + 20) @(negedge clk);
        sel();
        chk(!dout_oe, "R9 no late status", dout_oe, 0);
        desel();

        // R8: instruction during busy is ignored
        sel(); send(3'b101, 3); send(3, 6); send(16'h1111, 16); desel();
        mput(3, 16'h1111);
        sel(); send(3'b101, 3); send(4, 6); send(16'h2222, 16); desel();
        prog_wait();
        rd(4, "R8 busy write ignored");
        rd(3, "R8 first write kept");

        // R5: special commands
        special(2'b10, 1'b0, 16'h0);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        rd(3, "R5 erase all");
        rd(63, "R5 erase all last");
        special(2'b01, 1'b1, 16'h5AA5);
        for (int i = 0; i < 64; i++) model[i] = 16'h5AA5;
        rd(0, "R5 write all");
        rd(40, "R7 write all pattern");
        special(2'b00, 1'b0, 16'h0);           // disable
        wr(7, 16'h0000, 1'b0);
        er(8, 1'b0);
        rd(7, "R6 disabled write");
        rd(8, "R6 disabled erase");
        special(2'b10, 1'b0, 16'h0);
        rd(20, "R6 disabled erase all");
        special(2'b11, 1'b0, 16'h0);

        // R11: aborted frame
        sel(); send(3'b101, 3); send(12, 6); send(8'hCD, 8); desel();
        prog_wait();
        rd(12, "R11 aborted frame");

        // R3: byte view
        org = 1'b0;
        wr(10, 16'h003C, 1'b1);
        wr(11, 16'h00C3, 1'b1);
        rd(10, "R3 byte upper lane");
        rd(11, "R3 byte lower lane");
        er(11, 1'b1);
        rd(11, "R7 byte erase");
        rd(10, "R7 byte erase other lane");
        org = 1'b1;
        rd(5, "R3 word holds bytes");
        org = 1'b0;
        special(2'b01, 1'b1, 16'h0081);
        for (int i = 0; i < 64; i++) model[i] = 16'h8181;
        org = 1'b1;
        rd(33, "R3 byte write all");

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int a;
            logic [15:0] d;
            org = $urandom_range(0, 1);
            a = org ? $urandom_range(0, 63) : $urandom_range(0, 127);
            d = $urandom();
            if (!org) d[15:8] = 8'h0;
            case ($urandom_range(0, 2))
                0: wr(a, d, 1'b1);
                1: er(a, 1'b1);
                default: ;
            endcase
            rd(a, "R7 random op");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule